// File: doc/BRIEF.md
# Prescaled Baud Divider Calculator

This block turns a requested serial bit rate, given as an unsigned integer in bits per second, into the integer clock divider that a 48 MHz reference needs to approximate that rate. Slow requests use a coarse prescale of four, and all other requests use a prescale of one. The divider is rounded to the nearest integer, so that the achieved rate lands as close as possible to the request. Requests outside the supported window are pulled to the nearer edge of that window, and the block raises a flag when it does so.

The division runs serially, one quotient bit per clock, after a single-cycle load strobe. A done level reports that the divider, the prescale choice and the range flag are valid. Once the result is ready, a free-running counter emits a one-clock enable pulse every prescale × divider reference cycles, which is twice per bit period. A downstream checker can take the divider and the prescale flag and compute the achieved rate as 48 MHz / (2 × prescale × divider).

Top module: `baud_div_calc`

## Requirements
- R1: While reset is held, and directly after it is released, busy, done, tick, rangeErr and prescaleSlow are 0 and divider is 0.
- R2: A load strobe seen at a rising edge makes busy 1 after that edge. Exactly 32 edges later busy falls and done rises, and done then stays 1 until the next load.
- R3: With done at 1, divider equals floor((48000000 + P·rate) / (2·P·rate)), where rate is the clamped request and P is the prescale factor. This is division rounded to nearest, with halves rounded up.
- R4: The prescale factor is 4 when the clamped rate is 365 or lower, and 1 otherwise. prescaleSlow is 1 for the factor 4 and 0 for the factor 1.
- R5: A request below 300 is computed as 300, and a request above 2000000 is computed as 2000000. In both cases rangeErr is 1. A request inside the window leaves rangeErr at 0.
- R6: After done rises, tick is a one-cycle pulse. It first appears P·divider edges after the edge that raised done, and then repeats every P·divider edges.
- R7: tick stays 0 from the load edge until done rises again, so no partial period is ever emitted.
- R8: A load that arrives while busy is 1 restarts the computation from the new request, and done then rises 32 edges after that later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle strobe that captures reqRate and starts a calculation |
| reqRate | input | 32 | Requested bit rate in bits per second |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Result valid; tick generator running |
| divider | output | 32 | Rounded clock divider |
| prescaleSlow | output | 1 | 1 when the prescale factor is 4 |
| rangeErr | output | 1 | The request was clamped |
| tick | output | 1 | Enable pulse, twice per bit period |

## Verification
The bench aims at the boundaries where a careless design goes wrong. It checks the 365/366 prescale threshold, where an off-by-one in the comparison would give a divider about four times too small or too large. It checks a request such as 57600, whose exact quotient has a fraction above one half, which catches a design that truncates instead of rounding. It checks requests below 300 and above 2000000, where a design without clamping would produce an absurd divider or no range flag. It also issues a load during a calculation and a load while ticks are running: a design that fails to restart would raise done too early, and a design that reloads the counter early would emit a stray tick before done.

// File: rtl/baud_calc_pkg.sv
package baud_calc_pkg;

  // Strobes from the sequencer to the arithmetic and tick datapath.
  typedef struct packed {
    logic capture;  // latch clamped request and set up division
    logic step;     // perform one restoring-division iteration
    logic finish;   // last iteration: publish result and start ticks
  } calcStrobe_t;

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_calc_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadReq,
  output calcStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int CW = $clog2(STEPS + 1);

  typedef enum logic {S_IDLE, S_RUN} ctrlState_t;

  ctrlState_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe.capture = loadReq;
    strobe.step    = (state == S_RUN) && !loadReq;
    strobe.finish  = strobe.step && (stepCnt == CW'(STEPS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else if (strobe.capture) begin
      state   <= S_RUN;
      stepCnt <= '0;
      done    <= 1'b0;
    end else if (strobe.step) begin
      stepCnt <= stepCnt + 1'b1;
      if (strobe.finish) begin
        state <= S_IDLE;
        done  <= 1'b1;
      end
    end
  end

  assign busy = (state == S_RUN);

endmodule

// File: rtl/baud_dpath.sv
module baud_dpath
  import baud_calc_pkg::*;
#(
  parameter int W          = 32,
  parameter int REF_HZ     = 48_000_000,
  parameter int MIN_RATE   = 300,
  parameter int MAX_RATE   = 2_000_000,
  parameter int SLOW_LIMIT = 365,
  parameter int SLOW_PRE   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  calcStrobe_t   strobe,
  input  logic [W-1:0]  reqRate,
  output logic [W-1:0]  divider,
  output logic          prescaleSlow,
  output logic          rangeErr,
  output logic          tick
);

  localparam logic [W-1:0] REF_V   = W'(REF_HZ);
  localparam logic [W-1:0] MIN_V   = W'(MIN_RATE);
  localparam logic [W-1:0] MAX_V   = W'(MAX_RATE);
  localparam logic [W-1:0] SLOW_V  = W'(SLOW_LIMIT);
  localparam logic [W-1:0] PRE_V   = W'(SLOW_PRE);

  // Request conditioning
  logic [W-1:0] rateClamped;
  logic         rateOut;
  logic         slowSel;
  logic [W-1:0] denomNext;
  logic [W-1:0] numerNext;

  always_comb begin
    rateOut = 1'b0;
    rateClamped = reqRate;
    if (reqRate < MIN_V) begin
      rateClamped = MIN_V;
      rateOut = 1'b1;
    end else if (reqRate > MAX_V) begin
      rateClamped = MAX_V;
      rateOut = 1'b1;
    end
    slowSel   = (rateClamped <= SLOW_V);
    denomNext = (slowSel ? rateClamped * PRE_V : rateClamped) << 1;
    numerNext = REF_V + (denomNext >> 1);
  end

  // Restoring divider
  logic [W-1:0] denomR;
  logic [W-1:0] numShift;
  logic [W-1:0] remR;
  logic [W-1:0] quotR;
  logic [W:0]   remShift;
  logic         fits;
  logic [W-1:0] remNext;
  logic [W-1:0] quotNext;

  always_comb begin
    remShift = {remR, numShift[W-1]};
    fits     = (remShift >= {1'b0, denomR});
    remNext  = fits ? W'(remShift - {1'b0, denomR}) : remShift[W-1:0];
    quotNext = {quotR[W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      denomR       <= '0;
      numShift     <= '0;
      remR         <= '0;
      quotR        <= '0;
      divider      <= '0;
      prescaleSlow <= 1'b0;
      rangeErr     <= 1'b0;
    end else if (strobe.capture) begin
      denomR       <= denomNext;
      numShift     <= numerNext;
      remR         <= '0;
      quotR        <= '0;
      prescaleSlow <= slowSel;
      rangeErr     <= rateOut;
    end else if (strobe.step) begin
      numShift <= numShift << 1;
      remR     <= remNext;
      quotR    <= quotNext;
      if (strobe.finish) divider <= quotNext;
    end
  end

  // Tick generator: period is prescale x divider reference cycles
  logic [W-1:0] period;
  logic [W-1:0] tickCnt;
  logic         tickRun;

  assign period = prescaleSlow ? divider * PRE_V : divider;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      tickRun <= 1'b0;
      tick    <= 1'b0;
    end else if (strobe.capture) begin
      tickCnt <= '0;
      tickRun <= 1'b0;
      tick    <= 1'b0;
    end else if (strobe.finish) begin
      tickCnt <= '0;
      tickRun <= 1'b1;
      tick    <= 1'b0;
    end else if (tickRun) begin
      if (tickCnt == period - 1'b1) begin
        tickCnt <= '0;
        tick    <= 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
        tick    <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_div_calc.sv
module baud_div_calc
  import baud_calc_pkg::*;
#(
  parameter int W          = 32,
  parameter int REF_HZ     = 48_000_000,
  parameter int MIN_RATE   = 300,
  parameter int MAX_RATE   = 2_000_000,
  parameter int SLOW_LIMIT = 365,
  parameter int SLOW_PRE   = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] reqRate,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] divider,
  output logic         prescaleSlow,
  output logic         rangeErr,
  output logic         tick
);

  calcStrobe_t strobe;

  baud_ctrl #(.STEPS(W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadReq (load),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  baud_dpath #(
    .W          (W),
    .REF_HZ     (REF_HZ),
    .MIN_RATE   (MIN_RATE),
    .MAX_RATE   (MAX_RATE),
    .SLOW_LIMIT (SLOW_LIMIT),
    .SLOW_PRE   (SLOW_PRE)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqRate      (reqRate),
    .divider      (divider),
    .prescaleSlow (prescaleSlow),
    .rangeErr     (rangeErr),
    .tick         (tick)
  );

endmodule

// File: rtl/baud_div_calc_chk.sv
module baud_div_calc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         load,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] divider,
  input logic         tick
);

  // R1: busy and done are never both set
  p_busy_done_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R2: done holds until the next load
  p_done_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    done && !load |=> done);

  // R2: done rises only at the end of a calculation
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R3: the published divider stays put while done holds
  p_div_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    done && !load |=> $stable(divider));

  // R5: a clamped request never yields a zero divider
  p_div_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> divider != '0);

  // R6: tick is a single-cycle pulse
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R7: no tick without a valid result
  p_no_tick_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !tick);

  // R8: a load always drops done on the next cycle
  p_load_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    load |=> busy && !done);

endmodule

bind baud_div_calc baud_div_calc_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .load    (load),
  .busy    (busy),
  .done    (done),
  .divider (divider),
  .tick    (tick)
);

// File: tb/sim_baud_div_calc.sv
`timescale 1ns/1ps
module sim_baud_div_calc;

  logic        clk = 1'b0;
  logic        rstN;
  logic        load;
  logic [31:0] reqRate;
  logic        busy, done, prescaleSlow, rangeErr, tick;
  logic [31:0] divider;

  always #2.5 clk = ~clk;

  baud_div_calc u0 (
    .clk(clk), .rstN(rstN), .load(load), .reqRate(reqRate),
    .busy(busy), .done(done), .divider(divider),
    .prescaleSlow(prescaleSlow), .rangeErr(rangeErr), .tick(tick)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  bit     mBusy, mDone, mTick, mSlow, mErr, armed;
  int     mCnt, mPhase;
  longint mDiv, mPeriod;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mTick = 0; mSlow = 0; mErr = 0;
      mCnt = 0; mPhase = 0; mDiv = 0; mPeriod = 0;
    end else if (load) begin
      longint r, pre, den;
      r = reqRate;
      mErr = (r < 300) || (r > 2000000);
      if (r < 300) r = 300;
      if (r > 2000000) r = 2000000;
      pre = (r <= 365) ? 4 : 1;
      mSlow = (pre == 4);
      den = 2 * pre * r;
      mDiv = (48000000 + den / 2) / den;
      mPeriod = pre * mDiv;
      mBusy = 1; mDone = 0; mTick = 0; mCnt = 0;
    end else if (mBusy) begin
      mCnt++;
      mTick = 0;
      if (mCnt == 32) begin
        mBusy = 0; mDone = 1; mPhase = 0;
      end
    end else if (mDone) begin
      mPhase++;
      mTick = (mPhase == mPeriod);
      if (mTick) mPhase = 0;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      check(busy == mBusy, "R2/R8 busy", busy, mBusy);
      check(done == mDone, "R2/R8 done", done, mDone);
      check(tick == mTick, "R6/R7 tick", tick, mTick);
      if (mDone) begin
        check(divider == mDiv, "R3 divider", divider, mDiv);
        check(prescaleSlow == mSlow, "R4 prescale", prescaleSlow, mSlow);
        check(rangeErr == mErr, "R5 rangeErr", rangeErr, mErr);
      end
    end
  end

  task automatic doLoad(input longint rate);
    @(negedge clk);
    load = 1'b1;
    reqRate = 32'(rate);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; load = 1'b0; reqRate = '0; armed = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !tick, "R1 flags", {busy, done, tick}, 0);
    check(divider == 0 && !rangeErr && !prescaleSlow, "R1 result", divider, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !tick, "R1 after release", {busy, done, tick}, 0);
    armed = 1;

    // R2 R3 R6: fast rate, ticks every 12 cycles
    doLoad(2000000);   idle(80);
    // R3 rounding up (416.67 -> 417)
    doLoad(57600);     idle(900);
    // R3 R6: 9600 -> 2500, two full periods
    doLoad(9600);      idle(5100);
    // R4 threshold: 366 uses prescale 1, 365 uses prescale 4
    doLoad(366);       idle(40);
    doLoad(365);       idle(40);
    doLoad(300);       idle(40);
    // R5 clamping at both ends
    doLoad(100);       idle(40);
    doLoad(5000000);   idle(60);
    doLoad(0);         idle(40);
    // R8 restart while busy
    doLoad(9600);      idle(10);
    doLoad(1000000);   idle(100);
    // R7 load while ticks run: ticks stop until done again
    doLoad(2000000);   idle(50);
    doLoad(115200);    idle(700);
    finishRun();
  end

endmodule